// File: doc/BRIEF.md
# Three-Wire Wiper Host Sequencer

This block is a host-side master for an external 32-step up/down potentiometer that is steered through three lines: an active-low select, a direction level and an active-low increment strobe whose falling edge moves the wiper one tap. A client gives a target tap from 0 to 31 and a one-cycle start strobe. The sequencer compares the target with its own shadow copy of the wiper position, works out how many steps to take and in which direction, and then produces the select window and the increment pulses itself.

The shadow position is 15 after reset, which matches the device's mid-scale start. The shadow moves one tap at each increment falling edge and never wraps past either end. Each analog timing minimum is given as a parameter in nanoseconds together with the clock period. It is turned into a clock-cycle count rounded up, with a floor of one cycle. The increment line is always high again before the select line is raised, so the device drops into standby and does not take an extra step.

States: IDLE (waits for start), SELECT (select low and direction settled, held for the longer of the select setup and the direction setup), LOW (increment low), HIGH (increment high between pulses), PARK (increment high after the last pulse, before deselect), RELEASE (select high, deselect time), DONE (one-cycle completion). Transitions: IDLE to SELECT on start with a target other than the shadow; IDLE to DONE on start with a target equal to the shadow; SELECT to LOW when its time is up; LOW to HIGH when its time is up and steps remain; LOW to PARK when its time is up and no steps remain; HIGH to LOW when its time is up; PARK to RELEASE when its time is up; RELEASE to DONE when its time is up; DONE to IDLE always.

Top module: `wiper_seq`

## Requirements
- R1: After reset `sel_n` and `step_n` are 1, `busy` and `done` are 0, and `tap` is 15.
- R2: A start with target t while the shadow position is p produces exactly |t-p| falling edges on `step_n`. `dir_up` is 1 (toward tap 31) when t>p and 0 otherwise. `tap` moves one step toward t at each falling edge and ends at t.
- R3: `sel_n` falls in the cycle after the start is taken. It stays low with `step_n` high for SEL_CYC cycles before the first falling edge, where SEL_CYC is the larger of the select-setup and direction-setup counts.
- R4: Each low phase of `step_n` lasts LOW_CYC cycles. Each high phase between two pulses lasts HIGH_CYC cycles.
- R5: After the last pulse `step_n` stays high for PARK_CYC cycles before `sel_n` rises. PARK_CYC is the larger of the increment-to-deselect and direction-hold counts. `step_n` is low only while `sel_n` is low.
- R6: After `sel_n` rises it stays high for DESEL_CYC cycles, and then `done` is 1 for exactly one cycle. `busy` is 1 from the cycle after the start is taken through the `done` cycle, and 0 otherwise.
- R7: `dir_up` does not change while `sel_n` is low.
- R8: A start whose target equals the shadow position gives no activity on `sel_n` or `step_n`. `busy` and `done` are then both 1 in the single cycle after the start.
- R9: A start that arrives while `busy` is 1, including the `done` cycle, is ignored. The running move ends at its own target, and no new select window follows.
- R10: Each timing count is ceil(time_ns / CLK_PERIOD_NS) with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to move the wiper |
| target | input | TAP_W | Requested tap, 0 to 31 |
| sel_n | output | 1 | Device select, active low |
| dir_up | output | 1 | Direction level, 1 = toward the highest tap |
| step_n | output | 1 | Increment strobe, the device steps on its falling edge |
| tap | output | TAP_W | Shadow copy of the wiper position |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse when a move is complete |

## Verification
Two functions can land in the same cycle: a new start request and the completion pulse. The bench raises start with a different target exactly in the cycle where `done` is seen. It then requires that `busy` falls, that `sel_n` stays high and that the shadow tap stays at the old target, so the request is dropped and not queued. A second collision puts a start in the middle of an increment low phase. That move must still finish with the original pulse count and timing.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_LOW,
        ST_HIGH,
        ST_PARK,
        ST_RELEASE,
        ST_DONE
    } wseq_state_e;

    // Clock cycles covering a minimum time, rounded up, at least one.
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wseq_timer.sv
module wseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // A phase loaded with N lasts N cycles: expired in its last cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/wseq_shadow.sv
module wseq_shadow #(
    parameter int TAP_W     = 5,
    parameter int RESET_TAP = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [TAP_W-1:0] target,
    input  logic             step,
    output logic [TAP_W-1:0] pos,
    output logic             up,
    output logic [TAP_W-1:0] remaining
);

    localparam logic [TAP_W-1:0] MAX_TAP = {TAP_W{1'b1}};

    logic [TAP_W-1:0] pos_q;
    logic             up_q;
    logic [TAP_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= TAP_W'(RESET_TAP);
            up_q  <= 1'b0;
            rem_q <= '0;
        end else if (accept) begin
            up_q  <= (target > pos_q);
            rem_q <= (target > pos_q) ? (target - pos_q) : (pos_q - target);
        end else if (step) begin
            if (up_q) begin
                pos_q <= (pos_q == MAX_TAP) ? pos_q : pos_q + TAP_W'(1);
            end else begin
                pos_q <= (pos_q == '0) ? pos_q : pos_q - TAP_W'(1);
            end
            rem_q <= (rem_q == '0) ? rem_q : rem_q - TAP_W'(1);
        end
    end

    assign pos       = pos_q;
    assign up        = up_q;
    assign remaining = rem_q;

    // R2: the shadow never jumps by more than one tap
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != $past(pos_q)) |->
            ((pos_q == $past(pos_q) + TAP_W'(1)) || (pos_q == $past(pos_q) - TAP_W'(1))));

    // R2: the shadow moves only in the direction taken at acceptance
    a_r2_dir_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != $past(pos_q)) |-> ((pos_q > $past(pos_q)) == $past(up_q)));

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq
    import wseq_pkg::*;
#(
    parameter int CLK_PERIOD_NS   = 10,
    parameter int T_SEL_SETUP_NS  = 100,
    parameter int T_DIR_SETUP_NS  = 2900,
    parameter int T_STEP_LOW_NS   = 1000,
    parameter int T_STEP_HIGH_NS  = 1000,
    parameter int T_DIR_HOLD_NS   = 100,
    parameter int T_STEP_DESEL_NS = 1000,
    parameter int T_DESEL_NS      = 100,
    parameter int TAP_W           = 5,
    parameter int RESET_TAP       = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAP_W-1:0] target,
    output logic             sel_n,
    output logic             dir_up,
    output logic             step_n,
    output logic [TAP_W-1:0] tap,
    output logic             busy,
    output logic             done
);

    localparam int SEL_CYC   = imax(ns_to_cyc(T_SEL_SETUP_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_DIR_SETUP_NS, CLK_PERIOD_NS));
    localparam int LOW_CYC   = ns_to_cyc(T_STEP_LOW_NS, CLK_PERIOD_NS);
    localparam int HIGH_CYC  = ns_to_cyc(T_STEP_HIGH_NS, CLK_PERIOD_NS);
    localparam int PARK_CYC  = imax(ns_to_cyc(T_STEP_DESEL_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_DIR_HOLD_NS, CLK_PERIOD_NS));
    localparam int DESEL_CYC = ns_to_cyc(T_DESEL_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = imax(imax(SEL_CYC, LOW_CYC),
                                    imax(imax(HIGH_CYC, PARK_CYC), DESEL_CYC));
    localparam int CW        = $clog2(MAX_CYC + 1);

    wseq_state_e      state_q, state_d;
    logic             t_load, t_expired;
    logic [CW-1:0]    t_val;
    logic             accept, step;
    logic [TAP_W-1:0] remaining;

    assign accept = (state_q == ST_IDLE) && start;
    assign step   = (state_q != ST_LOW) && (state_d == ST_LOW);
    assign t_load = (state_q != state_d);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (target == tap) ? ST_DONE : ST_SELECT;
                end
            end
            ST_SELECT:  if (t_expired) state_d = ST_LOW;
            ST_LOW:     if (t_expired) state_d = (remaining == '0) ? ST_PARK : ST_HIGH;
            ST_HIGH:    if (t_expired) state_d = ST_LOW;
            ST_PARK:    if (t_expired) state_d = ST_RELEASE;
            ST_RELEASE: if (t_expired) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase length of the state being entered
    always_comb begin
        unique case (state_d)
            ST_SELECT:  t_val = CW'(SEL_CYC);
            ST_LOW:     t_val = CW'(LOW_CYC);
            ST_HIGH:    t_val = CW'(HIGH_CYC);
            ST_PARK:    t_val = CW'(PARK_CYC);
            ST_RELEASE: t_val = CW'(DESEL_CYC);
            default:    t_val = CW'(1);
        endcase
    end

    // Outputs
    always_comb begin
        sel_n  = 1'b1;
        step_n = 1'b1;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_SELECT:  sel_n = 1'b0;
            ST_LOW: begin
                sel_n  = 1'b0;
                step_n = 1'b0;
            end
            ST_HIGH:    sel_n = 1'b0;
            ST_PARK:    sel_n = 1'b0;
            ST_RELEASE: sel_n = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    wseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    wseq_shadow #(.TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .target    (target),
        .step      (step),
        .pos       (tap),
        .up        (dir_up),
        .remaining (remaining)
    );

    // R5: increment strobe only inside a select window
    a_r5_step_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !step_n |-> !sel_n);

    // R5: deselect only with the strobe parked high
    a_r5_park_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (step_n && $past(step_n)));

    // R7: direction stays put for the whole select window
    a_r7_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !$past(sel_n)) |-> $stable(dir_up));

    // R6: completion is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request during a move does not reopen the select window
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_n && start) |=> $stable(dir_up));

endmodule

// File: tb/sim_wiper_seq.sv
`timescale 1ns/1ps
module sim_wiper_seq;

    localparam int CLK_NS = 100;
    localparam int TW     = 5;

    function automatic int cyc(input int t_ns);
        int c;
        c = (t_ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // R10: expected phase lengths
    localparam int E_SEL   = 29;
    localparam int E_LOW   = 10;
    localparam int E_HIGH  = 10;
    localparam int E_PARK  = 10;
    localparam int E_DESEL = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] target = '0;
    logic          sel_n, dir_up, step_n, busy, done;
    logic [TW-1:0] tap;

    int n_checks = 0;
    int n_fail   = 0;
    int mpos     = 15;
    longint cycles = 0;

    wiper_seq #(.CLK_PERIOD_NS(CLK_NS)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .target (target),
        .sel_n  (sel_n),
        .dir_up (dir_up),
        .step_n (step_n),
        .tap    (tap),
        .busy   (busy),
        .done   (done)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // poke: 0 none, 1 start during first low phase, 2 start in the done cycle
    task automatic move(input int tgt, input int poke);
        int  steps, falls, seg, n;
        bit  pcs, pinc, seen_done, ud0, ud_bad, busy_bad, poked;
        steps = absdiff(tgt, mpos);
        @(negedge clk);
        start  = 1'b1;
        target = TW'(tgt);
        @(negedge clk);
        start = 1'b0;
        pcs = 1'b1; pinc = 1'b1; seg = 0; falls = 0; n = 0;
        seen_done = 0; ud_bad = 0; busy_bad = 0; poked = 0; ud0 = 1'b0;
        while (!seen_done && n < 5000) begin
            if (n > 0) @(negedge clk);
            if (start) start = 1'b0;
            n++;
            if (!busy) busy_bad = 1;
            if (pcs && !sel_n) begin
                ud0 = dir_up;
                check(ud0 == (tgt > mpos), "R2 direction", ud0, tgt > mpos);
                check(n == 1, "R3 select falls after accept", n, 1);
                seg = 1;
            end else if (pinc && !step_n) begin
                falls++;
                if (falls == 1) check(seg == E_SEL, "R3 select setup", seg, E_SEL);
                else            check(seg == E_HIGH, "R4 high phase", seg, E_HIGH);
                check(int'(tap) == ((tgt > mpos) ? mpos + falls : mpos - falls),
                      "R2 tap per step", tap, (tgt > mpos) ? mpos + falls : mpos - falls);
                seg = 1;
                if (poke == 1 && !poked) begin
                    start  = 1'b1;
                    target = TW'(31 - tgt);
                    poked  = 1;
                end
            end else if (!pinc && step_n) begin
                check(seg == E_LOW, "R4 low phase", seg, E_LOW);
                seg = 1;
            end else if (!pcs && sel_n) begin
                check(seg == E_PARK, "R5 park before deselect", seg, E_PARK);
                check(step_n, "R5 strobe high at deselect", step_n, 1);
                seg = 1;
            end else if (done) begin
                seen_done = 1;
                if (steps == 0) begin
                    check(n == 1 && sel_n, "R8 equal target completes at once", n, 1);
                end else begin
                    check(seg == E_DESEL, "R6 deselect time", seg, E_DESEL);
                end
            end else begin
                seg++;
            end
            if (!step_n && sel_n) check(0, "R5 strobe outside window", 0, 1);
            if (!sel_n && dir_up != ud0) ud_bad = 1;
            pcs  = sel_n;
            pinc = step_n;
        end
        check(seen_done, "R6 done reached", seen_done, 1);
        check(!busy_bad, "R6 busy during move", busy_bad, 0);
        check(!ud_bad, "R7 direction steady", ud_bad, 0);
        check(falls == steps, "R2 pulse count", falls, steps);
        check(int'(tap) == tgt, "R2 final tap", tap, tgt);
        if (poke == 2) begin
            start  = 1'b1;
            target = TW'(31 - tgt);
        end
        @(negedge clk);
        start = 1'b0;
        check(!done, "R6 done one cycle", done, 0);
        check(!busy, "R6 busy cleared", busy, 0);
        if (poke != 0) begin
            @(negedge clk);
            check(sel_n && !busy, "R9 late start ignored", busy, 0);
            check(int'(tap) == tgt, "R9 tap unchanged", tap, tgt);
        end
        mpos = tgt;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        check(E_SEL == mx(cyc(100), cyc(2900)) && E_DESEL == cyc(100) &&
              E_PARK == mx(cyc(1000), cyc(100)), "R10 rounding", E_SEL, mx(cyc(100), cyc(2900)));
        repeat (3) @(negedge clk);
        check(sel_n && step_n && !busy && !done, "R1 reset outputs", {sel_n, step_n, busy, done}, 4'b1100);
        check(tap == 5'd15, "R1 reset tap", tap, 15);
        rst_n = 1'b1;
        @(negedge clk);
        check(tap == 5'd15 && sel_n, "R1 after release", tap, 15);

        move(15, 0);   // R8
        move(31, 0);   // up to top end
        move(31, 0);   // R8 at top
        move(0, 0);    // full sweep down
        move(0, 2);    // R8 plus R9 collision with done
        move(1, 0);
        move(7, 1);    // R9 start in low phase
        move(3, 2);    // R9 collision with done
        for (int i = 0; i < 25; i++) begin
            int t, p;
            t = int'($urandom_range(0, 31));
            p = int'($urandom_range(0, 3));
            move(t, (p == 3) ? 1 : ((p == 2) ? 2 : 0));
        end
        finish_run();
    end

endmodule